// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

A bank of 32 general-purpose pins controlled through a small memory-mapped register bus. Software drives pin values and directions, reads back the synchronised pad levels, and chooses for every pin whether a rising edge, a falling edge, a high level or a low level counts as an event. Detected events are latched into a sticky status register. A single interrupt line summarises the whole bank.

Each register sits in its own 16-byte slot. The slot base is a plain read/write location. Base plus 0x4 sets the bits written as one, and base plus 0x8 clears the bits written as one. Two independent enable registers shape interrupts. One decides whether a pin's events reach the status register at all. The other only masks a status bit's contribution to the interrupt output.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, `pad_out` and `pad_oe` are zero and `irq` is low.
- R2: Register slots are 0x00 output data, 0x10 input data, 0x20 direction, 0x30 capture enable, 0x40 interrupt enable, 0x50 trigger level select, 0x60 trigger polarity and 0x70 status. Offset +0x0 overwrites all bits, +0x4 sets the ones written, and +0x8 clears the ones written. Offset +0xC and writes with address bits [1:0] nonzero change nothing.
- R3: `pad_out` follows the output data register and `pad_oe` follows the direction register (1 = output), in the cycle after the write.
- R4: The input data register returns `pad_in` delayed by two clocks, whatever the direction, and ignores writes.
- R5: With level select 0 a pin is edge-sensitive: polarity 1 detects rising and polarity 0 detects falling. The {polarity, level} codes are falling 0, low 1, rising 2 and high 3. A status bit sets three clocks after the pad transition.
- R6: With level select 1 a pin is level-sensitive: polarity 1 means high and polarity 0 means low. Its status bit re-sets on every cycle the level is present, so it cannot be cleared while the level persists.
- R7: A pin whose capture-enable bit is 0 never sets its status bit.
- R8: `irq` is high exactly when some bit is set in both status and interrupt enable. Interrupt enable has no effect on status.
- R9: Status bits clear only through the +0x8 alias. Writing all ones clears every bit, and plain or set-alias writes to status have no effect.
- R10: When a captured event and a clear of the same status bit fall in one cycle, the bit stays set.
- R11: An edge sets status once. After a clear, the bit stays clear while the pad holds its new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 7 | Byte address within the bank |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register (combinational) |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output data to pad drivers |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined bank interrupt |

## Verification
A register write takes effect at the clock edge that samples the strobe, so the bench reads it back at the following falling edge. A pad change is visible in the input data register after two rising edges, and it reaches status and `irq` after the third. The bench checks at exactly those falling edges, and it checks one edge earlier as well, to prove that nothing arrives early. Read data is combinational, so it is sampled one nanosecond after the address is set, still away from any rising edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int PIN_COUNT = 32;
    localparam int SEL_LSB   = 4;
    localparam int SEL_W     = 3;
    localparam int KIND_LSB  = 2;
    localparam int KIND_W    = 2;
    localparam int ADDR_W    = SEL_LSB + SEL_W;
    localparam int REG_COUNT = 1 << SEL_W;

    typedef logic [PIN_COUNT-1:0] pins_t;

    typedef enum logic [SEL_W-1:0] {
        REG_DOUT  = 3'd0,
        REG_DIN   = 3'd1,
        REG_OE    = 3'd2,
        REG_CAPEN = 3'd3,
        REG_IRQEN = 3'd4,
        REG_LEVEL = 3'd5,
        REG_POL   = 3'd6,
        REG_STAT  = 3'd7
    } reg_sel_e;

    typedef enum logic [KIND_W-1:0] {
        ACC_WRITE = 2'd0,
        ACC_SET   = 2'd1,
        ACC_CLR   = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    // {polarity, level} per pin
    typedef enum logic [1:0] {
        TRIG_FALL = 2'd0,
        TRIG_LOW  = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_HIGH = 2'd3
    } trig_e;

    typedef struct packed {
        logic      wr;
        reg_sel_e  sel;
        acc_kind_e kind;
    } bus_op_t;

    function automatic pins_t apply_op(pins_t old, pins_t wdata, acc_kind_e kind);
        case (kind)
            ACC_WRITE: return wdata;
            ACC_SET:   return old | wdata;
            ACC_CLR:   return old & ~wdata;
            default:   return old;
        endcase
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync
    import gpio_bank_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t async_in,
    output pins_t sync_out
);

    pins_t stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect
    import gpio_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t cur,
    input  pins_t level_sel,
    input  pins_t polarity,
    output pins_t hit
);

    pins_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur;
    end

    for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
        trig_e trig;
        assign trig = trig_e'({polarity[i], level_sel[i]});
        always_comb begin
            case (trig)
                TRIG_FALL: hit[i] = prev_q[i] & ~cur[i];
                TRIG_LOW:  hit[i] = ~cur[i];
                TRIG_RISE: hit[i] = cur[i] & ~prev_q[i];
                default:   hit[i] = cur[i];
            endcase
        end
    end

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  pins_t             wdata,
    input  pins_t             din,
    input  pins_t             hit,
    output pins_t             rdata,
    output pins_t             dout,
    output pins_t             oe,
    output pins_t             capen,
    output pins_t             irqen,
    output pins_t             level_sel,
    output pins_t             polarity,
    output pins_t             stat
);

    bus_op_t op;
    pins_t   bank [REG_COUNT];

    assign op.wr   = wr_en && (addr[KIND_LSB-1:0] == '0);
    assign op.sel  = reg_sel_e'(addr[SEL_LSB +: SEL_W]);
    assign op.kind = acc_kind_e'(addr[KIND_LSB +: KIND_W]);

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        if (i == int'(REG_DIN)) begin : g_in
            assign bank[i] = din;
        end else if (i == int'(REG_STAT)) begin : g_stat
            pins_t q;
            pins_t clr_mask;
            assign clr_mask = (op.wr && op.sel == REG_STAT && op.kind == ACC_CLR) ? wdata : '0;
            always_ff @(posedge clk) begin
                if (rst) q <= '0;
                else     q <= (q & ~clr_mask) | (hit & bank[REG_CAPEN]);
            end
            assign bank[i] = q;
        end else begin : g_ctl
            pins_t q;
            always_ff @(posedge clk) begin
                if (rst)                                    q <= '0;
                else if (op.wr && op.sel == reg_sel_e'(i))  q <= apply_op(q, wdata, op.kind);
            end
            assign bank[i] = q;
        end
    end

    assign rdata     = bank[op.sel];
    assign dout      = bank[REG_DOUT];
    assign oe        = bank[REG_OE];
    assign capen     = bank[REG_CAPEN];
    assign irqen     = bank[REG_IRQEN];
    assign level_sel = bank[REG_LEVEL];
    assign polarity  = bank[REG_POL];
    assign stat      = bank[REG_STAT];

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       pad_in,
    output logic [31:0]       pad_out,
    output logic [31:0]       pad_oe,
    output logic              irq
);

    pins_t din_sync;
    pins_t hit;
    pins_t capen_q;
    pins_t irqen_q;
    pins_t level_q;
    pins_t pol_q;
    pins_t stat_q;

    gpio_bank_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (din_sync)
    );

    gpio_bank_detect u_detect (
        .clk       (clk),
        .rst       (rst),
        .cur       (din_sync),
        .level_sel (level_q),
        .polarity  (pol_q),
        .hit       (hit)
    );

    gpio_bank_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .din       (din_sync),
        .hit       (hit),
        .rdata     (bus_rdata),
        .dout      (pad_out),
        .oe        (pad_oe),
        .capen     (capen_q),
        .irqen     (irqen_q),
        .level_sel (level_q),
        .polarity  (pol_q),
        .stat      (stat_q)
    );

    assign irq = |(stat_q & irqen_q);

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
    import gpio_bank_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input pins_t pad_in,
    input pins_t din,
    input pins_t hit,
    input pins_t capen,
    input pins_t irqen,
    input pins_t stat,
    input logic  irq
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                    since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat == '0 && capen == '0 && irqen == '0 && !irq));

    // R4
    din_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (din == $past(pad_in, 2)));

    // R7
    capture_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (stat & ~$past(stat) & ~$past(capen)) == '0);

    // R10
    event_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(hit & capen) & ~stat) == '0);

    // R8
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (irqen == '0) |-> !irq);

    // R8
    irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (stat == '0) |-> !irq);

endmodule

bind gpio_irq_bank gpio_irq_bank_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .pad_in (pad_in),
    .din    (din_sync),
    .hit    (hit),
    .capen  (capen_q),
    .irqen  (irqen_q),
    .stat   (stat_q),
    .irq    (irq)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;

    localparam logic [6:0] A_DOUT = 7'h00, A_DIN = 7'h10, A_OE = 7'h20, A_CAP = 7'h30,
                           A_IEN = 7'h40, A_LEV = 7'h50, A_POL = 7'h60, A_STAT = 7'h70;
    localparam logic [6:0] SET = 7'h4, CLR = 7'h8, RSV = 7'hC;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    gpio_irq_bank uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called just after a falling edge; returns just after the next one
    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic expect_reg(input string req, input logic [6:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset;
        for (int r = 0; r < 8; r++) expect_reg("R1 reg", 7'(r * 16), 32'h0);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_alias;
        wr(A_DOUT, 32'hA5A5_0F0F);
        expect_reg("R2 plain", A_DOUT, 32'hA5A5_0F0F);
        check("R3 pad_out", pad_out, 32'hA5A5_0F0F);
        wr(A_DOUT + SET, 32'h0000_F000);
        expect_reg("R2 set", A_DOUT, 32'hA5A5_FF0F);
        wr(A_DOUT + CLR, 32'hA500_0000);
        expect_reg("R2 clr", A_DOUT, 32'h00A5_FF0F);
        wr(A_DOUT + RSV, 32'hFFFF_FFFF);
        expect_reg("R2 reserved", A_DOUT, 32'h00A5_FF0F);
        wr(A_DOUT + 7'h1, 32'h0);
        expect_reg("R2 unaligned", A_DOUT, 32'h00A5_FF0F);
        check("R3 pad_out alias", pad_out, 32'h00A5_FF0F);
        wr(A_OE + SET, 32'hFFFF_0000);
        check("R3 pad_oe", pad_oe, 32'hFFFF_0000);
    endtask

    task automatic t_din;
        pad_in = 32'h1234_5678;
        cyc(1);
        expect_reg("R4 early", A_DIN, 32'h0);
        cyc(1);
        expect_reg("R4 sync", A_DIN, 32'h1234_5678);
        wr(A_DIN, 32'hFFFF_FFFF);
        expect_reg("R4 write ignored", A_DIN, 32'h1234_5678);
        pad_in = '0;
        cyc(3);
        expect_reg("R4 return", A_DIN, 32'h0);
    endtask

    task automatic t_edge;
        wr(A_CAP + SET, 32'h0000_0018);
        wr(A_POL + SET, 32'h0000_0008);
        wr(A_IEN + SET, 32'h0000_0008);
        pad_in[3] = 1'b1;
        cyc(2);
        expect_reg("R5 rise early", A_STAT, 32'h0);
        cyc(1);
        expect_reg("R5 rise", A_STAT, 32'h0000_0008);
        check("R8 irq on", {31'b0, irq}, 32'h1);
        wr(A_STAT + CLR, 32'h0000_0008);
        cyc(3);
        expect_reg("R11 single", A_STAT, 32'h0);
        check("R8 irq off", {31'b0, irq}, 32'h0);
        pad_in[4] = 1'b1;
        cyc(4);
        expect_reg("R5 fall ignores rise", A_STAT, 32'h0);
        pad_in[4] = 1'b0;
        cyc(3);
        expect_reg("R5 fall", A_STAT, 32'h0000_0010);
        check("R8 masked", {31'b0, irq}, 32'h0);
        wr(A_STAT + CLR, 32'h0000_0010);
        wr(A_CAP + CLR, 32'h0000_0018);
        pad_in[3] = 1'b0;
        cyc(4);
    endtask

    task automatic t_level;
        wr(A_LEV + SET, 32'h0000_0300);
        wr(A_POL + SET, 32'h0000_0100);
        wr(A_CAP + SET, 32'h0000_0100);
        pad_in[8] = 1'b1;
        cyc(3);
        expect_reg("R6 high", A_STAT, 32'h0000_0100);
        wr(A_STAT + CLR, 32'h0000_0100);
        expect_reg("R10 event wins", A_STAT, 32'h0000_0100);
        pad_in[8] = 1'b0;
        cyc(3);
        wr(A_STAT + CLR, 32'h0000_0100);
        cyc(3);
        expect_reg("R6 inactive", A_STAT, 32'h0);
        wr(A_CAP + SET, 32'h0000_0200);
        cyc(1);
        expect_reg("R6 low", A_STAT, 32'h0000_0200);
    endtask

    task automatic t_capen_irq;
        wr(A_POL + SET, 32'h0000_1000);
        pad_in[12] = 1'b1;
        cyc(4);
        pad_in[12] = 1'b0;
        cyc(4);
        expect_reg("R7 gated", A_STAT, 32'h0000_0200);
        wr(A_IEN, 32'h0);
        check("R8 disabled", {31'b0, irq}, 32'h0);
        expect_reg("R8 status kept", A_STAT, 32'h0000_0200);
        wr(A_IEN + SET, 32'h0000_0200);
        check("R8 enabled", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_clear_all;
        wr(A_CAP, 32'h0);
        wr(A_STAT, 32'h0);
        expect_reg("R9 plain ignored", A_STAT, 32'h0000_0200);
        wr(A_STAT + SET, 32'hFFFF_0000);
        expect_reg("R9 set ignored", A_STAT, 32'h0000_0200);
        wr(A_STAT + CLR, 32'hFFFF_FFFF);
        expect_reg("R9 clear all", A_STAT, 32'h0);
        check("R9 irq", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset;
        cyc(1); t_alias;
        cyc(1); t_din;
        cyc(1); t_edge;
        cyc(1); t_level;
        cyc(1); t_capen_irq;
        cyc(1); t_clear_all;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule